// File: doc/BRIEF.md
# Double-Data-Rate IQ Transmit Interface

This block takes one complex baseband sample per clock, made of a 16-bit real (I) word and a 16-bit imaginary (Q) word in two's complement. It sends the pair to a digital-to-analog converter over one 16-bit bus that carries I while the clock is high and Q while the clock is low. Both words of a pair are taken into the output stage on the same rising edge. The stage then sends them on the two halves of the following clock cycle.

A forwarded clock goes out through the same kind of double-data-rate output cell as the data bits, with a constant 1 on the high half and a constant 0 on the low half. Its edges therefore line up with the data transitions, and the converter can sample shortly after each forwarded edge. A frame pin has no use for word-wide transfers and stays low. An input valid strobe controls capture. When the strobe is low, a build parameter selects one of two behaviours: repeat the last accepted pair, or send zeros.

Top module: `iq_ddr_tx`

## Requirements
- R1: A pair presented with `in_valid` high at rising edge k appears on `tx_data` as the I word during the high half of the cycle that begins at rising edge k+1.
- R2: During the low half of that same cycle, `tx_data` carries the Q word of the same pair.
- R3: Words pass through bit-exact as two's complement, including the extreme codes 16'h8000 and 16'h7FFF, with no sign or offset change.
- R4: Outside reset, `tx_clk` is 1 during every high half and 0 during every low half of the clock.
- R5: `tx_frame` is 0 at all times.
- R6: A rising edge with `rst` high (synchronous, active high) clears the captured pair and both output phases. During the following cycle `tx_data` is 0 in both halves and `tx_clk` is 0.
- R7: With `IDLE_MODE` set to repeat (the default), an edge with `in_valid` low keeps the last captured pair, so that pair is sent again. After a reset, that pair is all zeros.
- R8: With `IDLE_MODE` set to silent, an edge with `in_valid` low captures zeros, so both halves of the next output cycle are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; also selects the output half |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the input pair |
| in_i | input | 16 | Real (I) word, two's complement |
| in_q | input | 16 | Imaginary (Q) word, two's complement |
| tx_data | output | 16 | Double-data-rate bus: I while clk is high, Q while low |
| tx_clk | output | 1 | Forwarded clock from a constant 1/0 output cell |
| tx_frame | output | 1 | Frame pin, held low |

## Verification
The hardest situation to reach is the boundary where reset, idle and new data meet. Reset is asserted while valid pairs are streaming. Reset is then released with `in_valid` still low, so the repeat variant must send the cleared pair and not the pair that was in flight. The stimulus drives this sequence on two instances at once, one per idle variant. It also mixes bursts of extreme codes with random valid gaps, and it checks both halves of every cycle, sampled just after each edge.

// File: rtl/iq_ddr_pkg.sv
package iq_ddr_pkg;

    parameter int unsigned IQ_W = 16;

    typedef logic signed [IQ_W-1:0] iq_word_t;

    typedef struct packed {
        iq_word_t re;
        iq_word_t im;
    } iq_pair_t;

    typedef enum logic {
        IDLE_REPEAT = 1'b0,
        IDLE_SILENT = 1'b1
    } idle_mode_e;

    localparam iq_pair_t PAIR_ZERO = '0;

    // Value the capture stage takes on an edge without a valid strobe.
    function automatic iq_pair_t idle_fill(input idle_mode_e mode, input iq_pair_t last);
        return (mode == IDLE_SILENT) ? PAIR_ZERO : last;
    endfunction

endpackage

// File: rtl/iq_capture.sv
module iq_capture
    import iq_ddr_pkg::*;
#(
    parameter idle_mode_e IDLE_MODE = IDLE_REPEAT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  iq_pair_t in_pair,
    output iq_pair_t held_pair
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_pair <= PAIR_ZERO;
        end else if (valid) begin
            held_pair <= in_pair;
        end else begin
            held_pair <= idle_fill(IDLE_MODE, held_pair);
        end
    end

endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell (
    input  logic clk,
    input  logic rst,
    input  logic d_rise,
    input  logic d_fall,
    output logic q
);

    logic rise_r;
    logic fall_r;

    // Both phases are loaded on the same rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_r <= 1'b0;
            fall_r <= 1'b0;
        end else begin
            rise_r <= d_rise;
            fall_r <= d_fall;
        end
    end

    // Behavioural half-cycle select.
    assign q = clk ? rise_r : fall_r;

endmodule

// File: rtl/iq_ddr_tx.sv
module iq_ddr_tx
    import iq_ddr_pkg::*;
#(
    parameter idle_mode_e IDLE_MODE = IDLE_REPEAT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [IQ_W-1:0]     in_i,
    input  logic [IQ_W-1:0]     in_q,
    output logic [IQ_W-1:0]     tx_data,
    output logic                tx_clk,
    output logic                tx_frame
);

    localparam logic CLK_HI_LEVEL = 1'b1;
    localparam logic CLK_LO_LEVEL = 1'b0;
    localparam logic FRAME_LEVEL  = 1'b0;

    iq_pair_t in_pair;
    iq_pair_t held_pair;

    assign in_pair.re = iq_word_t'(in_i);
    assign in_pair.im = iq_word_t'(in_q);

    iq_capture #(.IDLE_MODE(IDLE_MODE)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .valid     (in_valid),
        .in_pair   (in_pair),
        .held_pair (held_pair)
    );

    for (genvar lane = 0; lane < IQ_W; lane++) begin : g_lane
        ddr_out_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .d_rise (held_pair.re[lane]),
            .d_fall (held_pair.im[lane]),
            .q      (tx_data[lane])
        );
    end

    ddr_out_cell u_clk_cell (
        .clk    (clk),
        .rst    (rst),
        .d_rise (CLK_HI_LEVEL),
        .d_fall (CLK_LO_LEVEL),
        .q      (tx_clk)
    );

    ddr_out_cell u_frame_cell (
        .clk    (clk),
        .rst    (rst),
        .d_rise (FRAME_LEVEL),
        .d_fall (FRAME_LEVEL),
        .q      (tx_frame)
    );

endmodule

// File: rtl/iq_ddr_tx_checker.sv
module iq_ddr_tx_checker
    import iq_ddr_pkg::*;
#(
    parameter idle_mode_e IDLE_MODE = IDLE_REPEAT
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [IQ_W-1:0] in_i,
    input logic [IQ_W-1:0] in_q,
    input logic [IQ_W-1:0] tx_data,
    input logic            tx_clk,
    input logic            tx_frame
);

    logic [IQ_W-1:0] cap_i  = '0;
    logic [IQ_W-1:0] cap_q  = '0;
    logic [IQ_W-1:0] pipe_i = '0;
    logic [IQ_W-1:0] pipe_q = '0;
    logic            live_q = 1'b0;
    logic            rst_q  = 1'b0;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        live_q <= !rst;
        if (rst) begin
            cap_i  <= '0;
            cap_q  <= '0;
            pipe_i <= '0;
            pipe_q <= '0;
        end else begin
            pipe_i <= cap_i;
            pipe_q <= cap_q;
            if (in_valid) begin
                cap_i <= in_i;
                cap_q <= in_q;
            end else if (IDLE_MODE == IDLE_SILENT) begin
                cap_i <= '0;
                cap_q <= '0;
            end
        end
    end

    AST_HIGH_HALF_I: assert property (@(negedge clk) disable iff (rst)
        live_q |-> tx_data == pipe_i); // R1
    AST_LOW_HALF_Q: assert property (@(posedge clk) disable iff (rst)
        live_q |-> tx_data == pipe_q); // R2
    AST_FWD_CLK_HIGH: assert property (@(negedge clk) disable iff (rst)
        live_q |-> tx_clk == 1'b1); // R4
    AST_FWD_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        live_q |-> tx_clk == 1'b0); // R4
    AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_frame == 1'b0); // R5
    AST_RESET_CLEARS: assert property (@(negedge clk) disable iff (rst)
        rst_q |-> (tx_data == '0 && tx_clk == 1'b0)); // R6

endmodule

bind iq_ddr_tx iq_ddr_tx_checker #(.IDLE_MODE(IDLE_MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .tx_data  (tx_data),
    .tx_clk   (tx_clk),
    .tx_frame (tx_frame)
);

// File: tb/iq_ddr_tx_test.sv
`timescale 1ns/1ps
module iq_ddr_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic [15:0] tx_data, tx_data_z;
    logic        tx_clk, tx_clk_z;
    logic        tx_frame, tx_frame_z;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    iq_ddr_tx uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .tx_data(tx_data), .tx_clk(tx_clk), .tx_frame(tx_frame)
    );

    iq_ddr_tx #(.IDLE_MODE(iq_ddr_pkg::IDLE_SILENT)) uut_z (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .tx_data(tx_data_z), .tx_clk(tx_clk_z), .tx_frame(tx_frame_z)
    );

    // Reference model: capture stage and output stage, repeat and silent variants.
    int    cap_i = 0, cap_q = 0, out_i = 0, out_q = 0;
    int    capz_i = 0, capz_q = 0, outz_i = 0, outz_q = 0;
    bit    out_live = 0;
    string cap_tag = "R6", out_tag = "R6", capz_tag = "R6", outz_tag = "R6";

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic model_edge(input bit r, input bit v, input int i, input int q, input string tag);
        if (r) begin
            cap_i = 0; cap_q = 0; out_i = 0; out_q = 0;
            capz_i = 0; capz_q = 0; outz_i = 0; outz_q = 0;
            cap_tag = "R6"; out_tag = "R6"; capz_tag = "R6"; outz_tag = "R6";
            out_live = 0;
        end else begin
            out_i = cap_i; out_q = cap_q; out_tag = cap_tag;
            outz_i = capz_i; outz_q = capz_q; outz_tag = capz_tag;
            out_live = 1;
            if (v) begin
                cap_i = i; cap_q = q; cap_tag = tag;
                capz_i = i; capz_q = q; capz_tag = tag;
            end else begin
                cap_tag = "R7";
                capz_i = 0; capz_q = 0; capz_tag = "R8";
            end
        end
    endtask

    task automatic check_high();
        string ct;
        ct = out_live ? "R4" : "R6";
        check({"R1 ", out_tag}, int'(tx_data), out_i);
        check({"R1 ", outz_tag}, int'(tx_data_z), outz_i);
        check(ct, int'(tx_clk), out_live ? 1 : 0);
        check(ct, int'(tx_clk_z), out_live ? 1 : 0);
        check("R5", int'(tx_frame), 0);
        check("R5", int'(tx_frame_z), 0);
    endtask

    task automatic check_low();
        string ct;
        ct = out_live ? "R4" : "R6";
        check({"R2 ", out_tag}, int'(tx_data), out_q);
        check({"R2 ", outz_tag}, int'(tx_data_z), outz_q);
        check(ct, int'(tx_clk), 0);
        check(ct, int'(tx_clk_z), 0);
        check("R5", int'(tx_frame), 0);
    endtask

    // Called 1 ns after a rising edge: drive, then check both halves of the next cycle.
    task automatic step(input bit r, input bit v, input logic [15:0] i, input logic [15:0] q,
                        input string tag);
        rst = r; in_valid = v; in_i = i; in_q = q;
        @(negedge clk); #1;
        check_low();
        @(posedge clk);
        model_edge(r, v, int'(i), int'(q), tag);
        #1;
        check_high();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        model_edge(1, 0, 0, 0, "R6");
        #1;
        check_high();
        for (int k = 0; k < 3; k++) step(1, 1, 16'h1234, 16'h5678, "R6");

        // R7 right after reset: the held pair is the cleared one.
        step(0, 0, 16'hAAAA, 16'h5555, "R7");
        step(0, 0, 16'hAAAA, 16'h5555, "R7");

        // R1 / R2: steady stream of distinct pairs.
        for (int k = 0; k < 8; k++)
            step(0, 1, 16'(16'h0101 * (k + 1)), 16'(16'hF0F0 - 16'h0111 * k), "R1");

        // R3: extreme two's complement codes.
        step(0, 1, 16'h8000, 16'h7FFF, "R3");
        step(0, 1, 16'h7FFF, 16'h8000, "R3");
        step(0, 1, 16'hFFFF, 16'h0001, "R3");
        step(0, 1, 16'h0000, 16'hFFFF, "R3");

        // R7 / R8: idle gap after data.
        for (int k = 0; k < 3; k++) step(0, 0, 16'hDEAD, 16'hBEEF, "R7");

        // Alternating strobe.
        for (int k = 0; k < 10; k++)
            step(0, k[0], 16'(16'h3000 + k), 16'(16'hC000 - k), "R7");

        // R6: reset in the middle of a stream, released with the strobe low.
        step(0, 1, 16'h4321, 16'h8765, "R1");
        step(1, 1, 16'h1111, 16'h2222, "R6");
        step(0, 0, 16'h3333, 16'h4444, "R6");
        step(0, 0, 16'h3333, 16'h4444, "R7");
        step(0, 1, 16'h5A5A, 16'hA5A5, "R1");

        // Random traffic with random gaps.
        for (int k = 0; k < 80; k++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(0, v, 16'($urandom), 16'($urandom), "R1");
        end
        step(0, 0, 16'h0, 16'h0, "R7");
        step(0, 0, 16'h0, 16'h0, "R7");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule